// File: doc/BRIEF.md
# Maskable interrupt cause aggregator

This block collects interrupt events for three sources (receive, transmit and miscellaneous) into three cause registers of `DATA_W` bits each. Every cause bit has its own mask bit and its own clear policy. Under that policy the bit is cleared either when software reads the cause register or when software writes a 1 to that bit. Hardware pulses on the event inputs set cause bits. Software can also raise a cause bit by writing the set-cause register. Mask bits change only through two write-only ports, one that sets mask bits and one that clears them. The current mask can be read back through a read-only view.

A summary register holds one bit for each source. The bit for a source is set while that source has any unmasked cause bit pending, and it stays set until software reads the summary register. The summary register has its own software mask. The single interrupt line is a registered OR of the summary bits that this mask leaves enabled. After reset every mask is full, so the line stays low until software opens both the source mask and the summary mask. The intended service flow is to mask the source, read and clear its causes, then unmask it again.

All registers sit on a simple word-addressed bus with a one-cycle registered read.

Top module: `irq_cause_agg`

## Requirements
- R1: Reset is synchronous and active high. It leaves every cause register at 0, every clear-mode register at 0, every source mask and the summary mask at all ones, and `irq_o` low.
- R2: A 1 on an event input bit sets the matching cause bit. Event bits are ordered receive in `evt_i[DATA_W-1:0]`, transmit in the next `DATA_W` bits, and miscellaneous in the top `DATA_W` bits.
- R3: Writing the set-cause register sets every cause bit where the written data is 1.
- R4: Writing the mask-set register sets mask bits where the data is 1. Writing the mask-clear register clears mask bits where the data is 1. Zero data bits leave the mask unchanged. Masking a bit does not change its cause bit. The mask-view register reads back the mask.
- R5: Writing the cause register clears the cause bits that have a data bit of 1 and a clear-mode bit of 0. Cause bits whose clear-mode bit is 1 ignore that write.
- R6: Reading the cause register returns its value before any clearing. The read then clears every cause bit whose clear-mode bit is 1. Bits whose clear-mode bit is 0 are unchanged by the read.
- R7: When an event and a clear reach the same cause bit in the same cycle, the event wins and the bit stays set.
- R8: Summary bit 0 (receive), bit 1 (transmit) and bit 2 (miscellaneous) are set while that source has any cause bit with its mask bit at 0. Masked cause bits never set a summary bit.
- R9: Reading the summary register returns its value and then clears it. A source that is still pending sets its summary bit again in the same update.
- R10: `irq_o` is a register that is high when a summary bit with a summary-mask bit of 0 is set. A summary mask of all ones holds the line low.
- R11: Reads return data on `rdata_o` with `rvalid_o` high in the cycle after `rd_en_i`. The address map is `addr_i[5:3]` = source (0 receive, 1 transmit, 2 miscellaneous) and `addr_i[2:0]` = 0 cause, 1 set-cause, 2 mask-set, 3 mask-clear, 4 clear-mode, 5 mask-view. Address 24 is the summary register and address 25 is the summary mask. Unmapped addresses read 0. Writes to read-only registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 6 | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| evt_i | input | 3*DATA_W | Hardware event pulses, one slice per source |
| irq_o | output | 1 | Registered combined interrupt line |

## Verification
The assertions assume that the bus issues at most one write or one read to a register in a given cycle. They also assume that event inputs are pulses that the block may sample on any edge. The clear-on-read property is applied only in cycles where no event or set-cause write is present, because R7 gives events priority over clears. The stimulus drives each bus access for exactly one cycle, away from the clock edge. Each same-cycle event and clear collision is deliberately paired with a single bus access, so the R7 checks cover both clear policies.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned NUM_GRP = 3;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned GRP_RX   = 0;
  localparam int unsigned GRP_TX   = 1;
  localparam int unsigned GRP_MISC = 2;

  typedef enum logic [2:0] {
    SUB_CAUSE = 3'd0,
    SUB_SET   = 3'd1,
    SUB_MSET  = 3'd2,
    SUB_MCLR  = 3'd3,
    SUB_MODE  = 3'd4,
    SUB_MVIEW = 3'd5
  } sub_e;

  localparam logic [ADDR_W-1:0] ADDR_PCAUSE = 6'd24;
  localparam logic [ADDR_W-1:0] ADDR_PMASK  = 6'd25;

  typedef struct packed {
    logic rd_cause;
    logic wr_cause;
    logic wr_set;
    logic wr_mset;
    logic wr_mclr;
    logic wr_mode;
  } grp_cmd_t;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_agg_pkg::*;
(
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output grp_cmd_t             cmd_o [NUM_GRP],
  output logic                 rd_pcause_o,
  output logic                 wr_pmask_o
);
  logic [2:0] grp_idx;
  logic [2:0] sub_idx;

  assign grp_idx = addr_i[5:3];
  assign sub_idx = addr_i[2:0];

  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_dec
      logic hit;
      assign hit = (grp_idx == 3'(g));
      assign cmd_o[g].rd_cause = hit && rd_en_i && (sub_idx == SUB_CAUSE);
      assign cmd_o[g].wr_cause = hit && wr_en_i && (sub_idx == SUB_CAUSE);
      assign cmd_o[g].wr_set   = hit && wr_en_i && (sub_idx == SUB_SET);
      assign cmd_o[g].wr_mset  = hit && wr_en_i && (sub_idx == SUB_MSET);
      assign cmd_o[g].wr_mclr  = hit && wr_en_i && (sub_idx == SUB_MCLR);
      assign cmd_o[g].wr_mode  = hit && wr_en_i && (sub_idx == SUB_MODE);
    end
  endgenerate

  assign rd_pcause_o = rd_en_i && (addr_i == ADDR_PCAUSE);
  assign wr_pmask_o  = wr_en_i && (addr_i == ADDR_PMASK);
endmodule

// File: rtl/irq_cause_group.sv
module irq_cause_group
  import irq_agg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt_i,
  input  grp_cmd_t          cmd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cause_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] mode_o,
  output logic              pend_o
);
  logic [DATA_W-1:0] cause_q, mask_q, mode_q;
  logic [DATA_W-1:0] clr_vec, set_vec;

  // Clear sources: write-1 on write-to-clear bits, read on read-to-clear bits
  always_comb begin
    clr_vec = '0;
    if (cmd_i.wr_cause) clr_vec = clr_vec | (wdata_i & ~mode_q);
    if (cmd_i.rd_cause) clr_vec = clr_vec | mode_q;
    set_vec = evt_i;
    if (cmd_i.wr_set) set_vec = set_vec | wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      mask_q  <= '1;
      mode_q  <= '0;
    end else begin
      cause_q <= (cause_q & ~clr_vec) | set_vec;
      if (cmd_i.wr_mset)      mask_q <= mask_q | wdata_i;
      else if (cmd_i.wr_mclr) mask_q <= mask_q & ~wdata_i;
      if (cmd_i.wr_mode)      mode_q <= wdata_i;
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign mode_o  = mode_q;
  assign pend_o  = |(cause_q & ~mask_q);

  a_r1_reset_masked: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1 && cause_q == '0));
  a_r7_event_sets: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));
  a_r4_mask_set: assert property (@(posedge clk) disable iff (rst)
    cmd_i.wr_mset |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  a_r4_mask_clr: assert property (@(posedge clk) disable iff (rst)
    (cmd_i.wr_mclr && !cmd_i.wr_mset) |=> ((mask_q & $past(wdata_i)) == '0));
  a_r6_cor_clears: assert property (@(posedge clk) disable iff (rst)
    (cmd_i.rd_cause && !cmd_i.wr_set && evt_i == '0) |=> ((cause_q & $past(mode_q)) == '0));
endmodule

// File: rtl/irq_pseudo_summary.sv
module irq_pseudo_summary
  import irq_agg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_GRP-1:0] pend_i,
  input  logic               rd_clr_i,
  input  logic               wr_mask_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  pcause_o,
  output logic [DATA_W-1:0]  pmask_o,
  output logic               irq_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_GRP;

  logic [DATA_W-1:0] pcause_q, pmask_q, pend_ext;
  logic              irq_q;

  assign pend_ext = {{PAD_W{1'b0}}, pend_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      pcause_q <= '0;
      pmask_q  <= '1;
      irq_q    <= 1'b0;
    end else begin
      pcause_q <= (rd_clr_i ? '0 : pcause_q) | pend_ext;
      if (wr_mask_i) pmask_q <= wdata_i;
      irq_q <= |(pcause_q & ~pmask_q);
    end
  end

  assign pcause_o = pcause_q;
  assign pmask_o  = pmask_q;
  assign irq_o    = irq_q;

  a_r8_pend_sets: assert property (@(posedge clk) disable iff (rst)
    (|pend_i) |=> ((pcause_q[NUM_GRP-1:0] & $past(pend_i)) == $past(pend_i)));
  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_clr_i && pend_i == '0) |=> (pcause_q == '0));
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (pmask_q == '1) |=> !irq_q);
endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en_i,
  input  logic                      rd_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      rvalid_o,
  input  logic [NUM_GRP*DATA_W-1:0] evt_i,
  output logic                      irq_o
);
  grp_cmd_t          cmd [NUM_GRP];
  logic              rd_pcause, wr_pmask;
  logic [DATA_W-1:0] cause_a [NUM_GRP];
  logic [DATA_W-1:0] mask_a  [NUM_GRP];
  logic [DATA_W-1:0] mode_a  [NUM_GRP];
  logic [NUM_GRP-1:0] pend;
  logic [DATA_W-1:0] pcause, pmask;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              rvalid_q;

  irq_bus_decode u_dec (
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .addr_i      (addr_i),
    .cmd_o       (cmd),
    .rd_pcause_o (rd_pcause),
    .wr_pmask_o  (wr_pmask)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_grp
      irq_cause_group #(.DATA_W(DATA_W)) u_grp (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt_i[g*DATA_W +: DATA_W]),
        .cmd_i   (cmd[g]),
        .wdata_i (wdata_i),
        .cause_o (cause_a[g]),
        .mask_o  (mask_a[g]),
        .mode_o  (mode_a[g]),
        .pend_o  (pend[g])
      );
    end
  endgenerate

  irq_pseudo_summary #(.DATA_W(DATA_W)) u_sum (
    .clk       (clk),
    .rst       (rst),
    .pend_i    (pend),
    .rd_clr_i  (rd_pcause),
    .wr_mask_i (wr_pmask),
    .wdata_i   (wdata_i),
    .pcause_o  (pcause),
    .pmask_o   (pmask),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_d = '0;
    if (addr_i == ADDR_PCAUSE) begin
      rdata_d = pcause;
    end else if (addr_i == ADDR_PMASK) begin
      rdata_d = pmask;
    end else begin
      for (int i = 0; i < NUM_GRP; i++) begin
        if (addr_i[5:3] == 3'(i)) begin
          case (addr_i[2:0])
            SUB_CAUSE: rdata_d = cause_a[i];
            SUB_MODE:  rdata_d = mode_a[i];
            SUB_MVIEW: rdata_d = mask_a[i];
            default:   rdata_d = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rdata_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  a_r11_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rvalid_o);
endmodule

// File: tb/irq_cause_agg_tb.sv
module irq_cause_agg_tb;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]    addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          rvalid;
  logic [3*W-1:0] evt = '0;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct { logic [W-1:0] d; string t; } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  irq_cause_agg #(.DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .evt_i(evt), .irq_o(irq)
  );

  // Monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R11 unexpected read data: actual %h expected none", rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rdata !== e.d) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", e.t, rdata, e.d);
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [W-1:0] d, input logic [3*W-1:0] e);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1; evt = e;
    @(negedge clk); wr_en = 1'b0; evt = '0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, input logic [W-1:0] x, input string t, input logic [3*W-1:0] e);
    exp_t it;
    it.d = x; it.t = t;
    @(negedge clk); addr = a; rd_en = 1'b1; evt = e; sb.push_back(it);
    @(negedge clk); rd_en = 1'b0; evt = '0;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [3*W-1:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_irq(input logic x, input string t);
    n_chk++;
    if (irq !== x) begin
      n_fail++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, x);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    // R1 reset state
    rd(6'd0,  32'h0, "R1 rx cause", '0);
    rd(6'd5,  32'hFFFFFFFF, "R1 rx mask", '0);
    rd(6'd4,  32'h0, "R1 rx mode", '0);
    rd(6'd25, 32'hFFFFFFFF, "R1 summary mask", '0);
    rd(6'd13, 32'hFFFFFFFF, "R1 tx mask", '0);
    chk_irq(1'b0, "R1 irq low");
    // R2 event, R8 masked source ignored
    pulse({64'h0, 32'h5});
    rd(6'd0,  32'h5, "R2 rx event", '0);
    rd(6'd24, 32'h0, "R8 masked no summary", '0);
    // R3 set-cause
    wr(6'd9, 32'h100, '0);
    rd(6'd8, 32'h100, "R3 tx set-cause", '0);
    // R4 mask set/clear
    wr(6'd3, 32'h5, '0);
    rd(6'd5, 32'hFFFFFFFA, "R4 mask clear", '0);
    wr(6'd2, 32'h0, '0);
    rd(6'd5, 32'hFFFFFFFA, "R4 zero bits keep mask", '0);
    // R8 / R9 summary
    rd(6'd24, 32'h1, "R8 rx summary bit", '0);
    rd(6'd24, 32'h1, "R9 re-set while pending", '0);
    chk_irq(1'b0, "R10 summary mask blocks");
    wr(6'd25, 32'hFFFFFFF8, '0);
    idle(2);
    chk_irq(1'b1, "R10 irq raised");
    // R5 write-1-to-clear
    wr(6'd0, 32'h1, '0);
    rd(6'd0, 32'h4, "R5 w1c clears bit0", '0);
    rd(6'd0, 32'h4, "R6 read keeps w1c bit", '0);
    // R6 clear-on-read
    wr(6'd4, 32'h4, '0);
    rd(6'd4, 32'h4, "R11 mode readback", '0);
    wr(6'd0, 32'h4, '0);
    rd(6'd0, 32'h4, "R5 cor bit ignores write", '0);
    rd(6'd0, 32'h0, "R6 cor bit cleared", '0);
    rd(6'd24, 32'h1, "R9 summary sticky", '0);
    rd(6'd24, 32'h0, "R9 summary cleared", '0);
    idle(3);
    chk_irq(1'b0, "R10 irq falls");
    // R7 event beats clear, both policies
    rd(6'd0, 32'h0, "R7 cor read with event", {64'h0, 32'h4});
    rd(6'd0, 32'h4, "R7 event kept on cor", '0);
    rd(6'd0, 32'h0, "R6 cor clear again", '0);
    wr(6'd0, 32'h1, {64'h0, 32'h1});
    rd(6'd0, 32'h1, "R7 event kept on w1c", '0);
    wr(6'd0, 32'h1, '0);
    rd(6'd0, 32'h0, "R5 w1c clear", '0);
    rd(6'd24, 32'h1, "R9 sticky after collision", '0);
    rd(6'd24, 32'h0, "R9 cleared after collision", '0);
    // R8 misc position
    wr(6'd19, 32'hFFFFFFFF, '0);
    pulse({32'h80000000, 64'h0});
    rd(6'd24, 32'h4, "R8 misc summary bit", '0);
    idle(2);
    chk_irq(1'b1, "R10 misc irq");
    wr(6'd18, 32'hFFFFFFFF, '0);
    rd(6'd21, 32'hFFFFFFFF, "R4 misc mask set", '0);
    rd(6'd16, 32'h80000000, "R4 mask keeps cause", '0);
    rd(6'd24, 32'h4, "R9 sticky after mask", '0);
    rd(6'd24, 32'h0, "R8 masked gives no summary", '0);
    // R11 map corners
    rd(6'd30, 32'h0, "R11 unmapped reads zero", '0);
    wr(6'd5, 32'h0, '0);
    rd(6'd5, 32'hFFFFFFFA, "R11 mask view read-only", '0);
    // R10 summary mask gating
    wr(6'd11, 32'h100, '0);
    rd(6'd24, 32'h2, "R8 tx summary bit", '0);
    wr(6'd25, 32'hFFFFFFFF, '0);
    idle(2);
    chk_irq(1'b0, "R10 full mask blocks");
    wr(6'd25, 32'hFFFFFFFD, '0);
    idle(2);
    chk_irq(1'b1, "R10 tx enabled");
    idle(4);
    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R11 missing reads: actual %0d pending expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule